// File: doc/BRIEF.md
# DRAM bank command sequencer

This block turns a stream of simple memory requests into a legal command stream for a multi-bank DRAM. Each request names a direction (read or write), a bank, a row and a column. For every request the sequencer opens the row it needs with an activate, issues the read or write column command, and closes rows with a precharge when the row is wrong or when the page policy asks for it. It keeps the open row of every bank and a set of per-bank and shared timers, so the command stream never breaks the row-cycle, activate-to-column, precharge-recovery, bank-to-bank activate spacing or burst occupancy rules.

Requests are taken in order through a valid/ready handshake. There is a single holding slot. `req_ready` is high when the slot is empty, or in the cycle the held request's column command is chosen, so a back-to-back stream loses no cycle between column commands. The upstream side must hold `req_valid` and the request fields steady while `req_ready` is low. When the held request is blocked by a timer, the sequencer waits; it never lets a later request pass. A static `page_closed` input selects the page policy. A static `bl8_sel` input selects four or eight beats per column command. The response pulse `resp_valid` marks each column command as it appears on the command bus.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset `cmd_code` is 0 (no operation), `resp_valid` is 0, `req_ready` is 1, and no bank holds an open row, so the first request to any bank starts with an activate.
- R2: `cmd_code` carries one command per cycle with the encoding 0 = no operation, 1 = activate, 2 = read, 3 = write, 4 = precharge. No other value appears. `cmd_bank` names the target bank, `cmd_row` is the row for an activate, and `cmd_col` is the column for a read or write.
- R3: Read and write commands come out in the order their requests were accepted, with each request's bank, row and column. `resp_valid` is 1 exactly in the cycles that carry a read or write, and `resp_write` is 1 for a write.
- R4: A request is taken on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is high when no request is held, or when the held request's column command goes out at that edge.
- R5: A read or write to a bank comes at least T_RCD cycles after the activate to that bank. For a request to an idle bank with nothing else pending, the gap is exactly T_RCD.
- R6: Two activates to the same bank are at least T_RC cycles apart. An activate follows a precharge of the same bank by at least T_RP cycles.
- R7: Any two activates, to any banks, are at least T_RRD cycles apart.
- R8: A burst lasts 4 cycles when `bl8_sel` is 0 and 8 cycles when it is 1. Successive column commands are at least one burst apart, and exactly one burst apart for back-to-back hits to an open row. A precharge to a bank comes at least one burst after that bank's last column command.
- R9: With `page_closed` at 0, rows stay open after an access. A request to the open row gets only a column command. A request to another row of an open bank gets a precharge, then an activate.
- R10: With `page_closed` at 1, a bank is precharged once its burst has ended. The exception is when the held request already targets that same bank and row. In that case the column command is issued with no new activate.
- R11: Activates, and every precharge other than a policy close, go only to the bank of the oldest request not yet served, and an activate carries that request's row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| page_closed | input | 1 | Static page policy: 0 keeps rows open, 1 closes them after access |
| bl8_sel | input | 1 | Static burst length: 0 = 4 beats, 1 = 8 beats |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request slot can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| cmd_code | output | 3 | Command on the DRAM bus (encoding in R2) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row carried by an activate |
| cmd_col | output | COL_W | Column carried by a read or write |
| resp_valid | output | 1 | A column command is on the bus this cycle |
| resp_write | output | 1 | That column command is a write |

## Verification
A wrong open-row record shows up in one of two ways: a column command reaches a bank whose row was never activated, or an activate hits a bank that is still open. Either is seen on the command bus at the very next command for that bank. A timer that is loaded short shows up as a gap between commands below its limit, and the bench measures every such gap as the commands appear. A timer that never expires shows up as a request that stalls for good, which the scoreboard reports as an unserved request. A wrong page-policy decision is seen in the count of activates and precharges for a short directed pattern, and in the open or closed state of each bank, rebuilt from the bus, once traffic has drained.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } dcmd_e;
endpackage

// File: rtl/dseq_down_counter.sv
// Loadable down counter that rests at zero; zero means the guarded spacing has elapsed.
module dseq_down_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dseq_bank_state.sv
// Per-bank row state and timers: row cycle, activate-to-column, precharge recovery, burst.
module dseq_bank_state #(
  parameter int ROW_W = 14,
  parameter int T_RC  = 20,
  parameter int T_RCD = 5,
  parameter int T_RP  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_col,
  input  logic             do_pre,
  input  logic             closed_mode,
  input  logic [ROW_W-1:0] act_row,
  input  logic [2:0]       bl_m1,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             close_pend
);
  localparam int RC_W  = $clog2(T_RC + 1);
  localparam int RCD_W = $clog2(T_RCD + 1);
  localparam int RP_W  = $clog2(T_RP + 1);
  localparam logic [RC_W-1:0]  RC_LOAD  = RC_W'(T_RC - 1);
  localparam logic [RCD_W-1:0] RCD_LOAD = RCD_W'(T_RCD - 1);
  localparam logic [RP_W-1:0]  RP_LOAD  = RP_W'(T_RP - 1);

  logic rc_done, rcd_done, rp_done, bst_done;

  dseq_down_counter #(.W(RC_W)) u_rc (
    .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(RC_LOAD), .zero(rc_done));
  dseq_down_counter #(.W(RCD_W)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(RCD_LOAD), .zero(rcd_done));
  dseq_down_counter #(.W(RP_W)) u_rp (
    .clk(clk), .rst_n(rst_n), .load(do_pre), .load_val(RP_LOAD), .zero(rp_done));
  dseq_down_counter #(.W(3)) u_bst (
    .clk(clk), .rst_n(rst_n), .load(do_col), .load_val(bl_m1), .zero(bst_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open    <= 1'b0;
      open_row   <= '0;
      close_pend <= 1'b0;
    end else begin
      if (do_act) begin
        is_open  <= 1'b1;
        open_row <= act_row;
      end else if (do_pre) begin
        is_open  <= 1'b0;
      end
      if (do_pre)                     close_pend <= 1'b0;
      else if (do_col && closed_mode) close_pend <= 1'b1;
    end
  end

  assign act_ok = !is_open && rc_done && rp_done;
  assign col_ok = rcd_done;
  assign pre_ok = is_open && bst_done;
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dseq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int T_RC      = 20,
  parameter int T_RRD     = 3,
  parameter int T_RCD     = 5,
  parameter int T_RP      = 5,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_closed,
  input  logic              bl8_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              resp_valid,
  output logic              resp_write
);
  localparam int RRD_W = $clog2(T_RRD + 1);
  localparam logic [RRD_W-1:0] RRD_LOAD = RRD_W'(T_RRD - 1);

  // Holding slot for the oldest unserved request
  logic              hv, h_wr;
  logic [BANK_W-1:0] h_bank;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;

  logic [NUM_BANKS-1:0] b_open, b_act_ok, b_col_ok, b_pre_ok, b_pend;
  logic [NUM_BANKS-1:0] do_act, do_col, do_pre, close_req;
  logic [ROW_W-1:0]     b_row [NUM_BANKS];

  logic [2:0]        bl_m1;
  logic              rrd_zero, bus_zero;
  logic              close_any, cur_open, cur_hit, col_fire;
  logic [BANK_W-1:0] close_idx, nxt_bank;
  dcmd_e             nxt_cmd;

  assign bl_m1 = bl8_sel ? 3'd7 : 3'd3;

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      dseq_bank_state #(
        .ROW_W(ROW_W), .T_RC(T_RC), .T_RCD(T_RCD), .T_RP(T_RP)
      ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_act     (do_act[gb]),
        .do_col     (do_col[gb]),
        .do_pre     (do_pre[gb]),
        .closed_mode(page_closed),
        .act_row    (h_row),
        .bl_m1      (bl_m1),
        .is_open    (b_open[gb]),
        .open_row   (b_row[gb]),
        .act_ok     (b_act_ok[gb]),
        .col_ok     (b_col_ok[gb]),
        .pre_ok     (b_pre_ok[gb]),
        .close_pend (b_pend[gb])
      );
      // Policy close, held back when the waiting request hits this very row
      assign close_req[gb] = b_pend[gb] && b_pre_ok[gb] &&
                             !(hv && (h_bank == BANK_W'(gb)) && (b_row[gb] == h_row));
      assign do_act[gb] = (nxt_cmd == CMD_ACT) && (nxt_bank == BANK_W'(gb));
      assign do_pre[gb] = (nxt_cmd == CMD_PRE) && (nxt_bank == BANK_W'(gb));
      assign do_col[gb] = col_fire && (nxt_bank == BANK_W'(gb));
    end
  endgenerate

  // Shared timers: bank-to-bank activate spacing and data-bus occupancy
  dseq_down_counter #(.W(RRD_W)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(nxt_cmd == CMD_ACT), .load_val(RRD_LOAD), .zero(rrd_zero));
  dseq_down_counter #(.W(3)) u_bus (
    .clk(clk), .rst_n(rst_n), .load(col_fire), .load_val(bl_m1), .zero(bus_zero));

  // Lowest-numbered bank waiting for a policy close
  always_comb begin
    close_any = 1'b0;
    close_idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (close_req[i]) begin
        close_any = 1'b1;
        close_idx = BANK_W'(i);
      end
    end
  end

  assign cur_open = b_open[h_bank];
  assign cur_hit  = cur_open && (b_row[h_bank] == h_row);

  // One command per cycle; the held request is never bypassed by a later one
  always_comb begin
    nxt_cmd  = CMD_NOP;
    nxt_bank = h_bank;
    if (close_any) begin
      nxt_cmd  = CMD_PRE;
      nxt_bank = close_idx;
    end else if (hv) begin
      if (cur_hit) begin
        if (b_col_ok[h_bank] && bus_zero) nxt_cmd = h_wr ? CMD_WR : CMD_RD;
      end else if (cur_open) begin
        if (b_pre_ok[h_bank]) nxt_cmd = CMD_PRE;
      end else begin
        if (b_act_ok[h_bank] && rrd_zero) nxt_cmd = CMD_ACT;
      end
    end
  end

  assign col_fire  = (nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR);
  assign req_ready = !hv || col_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv     <= 1'b0;
      h_wr   <= 1'b0;
      h_bank <= '0;
      h_row  <= '0;
      h_col  <= '0;
    end else if (req_ready) begin
      hv <= req_valid;
      if (req_valid) begin
        h_wr   <= req_write;
        h_bank <= req_bank;
        h_row  <= req_row;
        h_col  <= req_col;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_code   <= CMD_NOP;
      cmd_bank   <= '0;
      cmd_row    <= '0;
      cmd_col    <= '0;
      resp_valid <= 1'b0;
      resp_write <= 1'b0;
    end else begin
      cmd_code   <= nxt_cmd;
      cmd_bank   <= nxt_bank;
      cmd_row    <= h_row;
      cmd_col    <= h_col;
      resp_valid <= col_fire;
      resp_write <= col_fire && h_wr;
    end
  end
endmodule

// File: rtl/dram_cmd_seq_chk.sv
module dram_cmd_seq_chk #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3,
  parameter int T_RC      = 20,
  parameter int T_RRD     = 3,
  parameter int T_RCD     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bl8_sel,
  input logic [2:0]        cmd_code,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              resp_valid
);
  localparam int CW = $clog2(T_RC + T_RRD + T_RCD + 16) + 1;
  localparam logic [CW-1:0] SAT = '1;

  logic          is_act, is_col;
  logic [CW-1:0] since_act_any, since_col_any;
  logic [CW-1:0] since_act [NUM_BANKS];

  assign is_act = (cmd_code == 3'd1);
  assign is_col = (cmd_code == 3'd2) || (cmd_code == 3'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act_any <= SAT;
      since_col_any <= SAT;
    end else begin
      if (is_act)                  since_act_any <= CW'(1);
      else if (since_act_any != SAT) since_act_any <= since_act_any + 1'b1;
      if (is_col)                  since_col_any <= CW'(1);
      else if (since_col_any != SAT) since_col_any <= since_col_any + 1'b1;
    end
  end

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code <= 3'd4); // R2
  AST_RESP_MARKS_COL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == is_col); // R3
  AST_ACT_SPACING_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_act_any >= CW'(T_RRD))); // R7
  AST_BURST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_col_any >= (bl8_sel ? CW'(8) : CW'(4)))); // R8

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bk
      always_ff @(posedge clk) begin
        if (!rst_n)                                    since_act[gb] <= SAT;
        else if (is_act && cmd_bank == BANK_W'(gb))    since_act[gb] <= CW'(1);
        else if (since_act[gb] != SAT)                 since_act[gb] <= since_act[gb] + 1'b1;
      end
      AST_ROW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && cmd_bank == BANK_W'(gb)) |-> (since_act[gb] >= CW'(T_RC))); // R6
      AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && cmd_bank == BANK_W'(gb)) |-> (since_act[gb] >= CW'(T_RCD))); // R5
    end
  endgenerate
endmodule

bind dram_cmd_seq dram_cmd_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .T_RC(T_RC), .T_RRD(T_RRD), .T_RCD(T_RCD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bl8_sel(bl8_sel),
  .cmd_code(cmd_code), .cmd_bank(cmd_bank), .resp_valid(resp_valid)
);

// File: tb/tb_dram_cmd_seq.sv
module tb_dram_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, BW = 3, RW = 14, CW = 10;
  localparam int T_RC = 20, T_RRD = 3, T_RCD = 5, T_RP = 5;

  logic clk = 0, rst_n = 0, page_closed = 0, bl8_sel = 0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic [2:0] cmd_code;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic resp_valid, resp_write;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_seq #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .T_RC(T_RC),
                 .T_RRD(T_RRD), .T_RCD(T_RCD), .T_RP(T_RP)) dut (
    .clk(clk), .rst_n(rst_n), .page_closed(page_closed), .bl8_sel(bl8_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .resp_valid(resp_valid), .resp_write(resp_write));

  typedef struct { bit wr; int bank; int row; int col; } req_t;
  req_t exp_q[$];
  int vectors = 0, miscompares = 0;
  int cyc = 0;
  bit bopen[NB];
  int brow[NB], last_act[NB], last_pre[NB], last_col[NB];
  int last_act_any = -1000, last_col_any = -1000;
  int act_cnt = 0, pre_cnt = 0;
  int act_times[$], col_times[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  initial for (int i = 0; i < NB; i++) begin
    bopen[i] = 0; brow[i] = 0; last_act[i] = -1000; last_pre[i] = -1000; last_col[i] = -1000;
  end

  // Monitor: rebuilds bank state from the bus and checks every command
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int b, bl;
      b = int'(cmd_bank);
      bl = bl8_sel ? 8 : 4;
      case (cmd_code)
        3'd0: chk(resp_valid == 0, "R3 resp without column", resp_valid, 0);
        3'd1: begin
          chk(!bopen[b], "R6 activate to open bank", bopen[b], 0);
          chk(cyc - last_act[b] >= T_RC, "R6 same-bank activate gap", cyc - last_act[b], T_RC);
          chk(cyc - last_pre[b] >= T_RP, "R6 precharge-to-activate gap", cyc - last_pre[b], T_RP);
          chk(cyc - last_act_any >= T_RRD, "R7 activate gap", cyc - last_act_any, T_RRD);
          if (exp_q.size() == 0) chk(0, "R11 activate with no request", b, -1);
          else begin
            chk(exp_q[0].bank == b, "R11 activate bank", b, exp_q[0].bank);
            chk(exp_q[0].row == int'(cmd_row), "R11 activate row", cmd_row, exp_q[0].row);
          end
          bopen[b] = 1; brow[b] = int'(cmd_row); last_act[b] = cyc; last_act_any = cyc;
          act_cnt++; act_times.push_back(cyc);
        end
        3'd2, 3'd3: begin
          if (exp_q.size() == 0) chk(0, "R3 column with no request", b, -1);
          else begin
            req_t e;
            e = exp_q.pop_front();
            chk(e.bank == b, "R3 column bank", b, e.bank);
            chk(e.col == int'(cmd_col), "R3 column address", cmd_col, e.col);
            chk(e.wr == (cmd_code == 3'd3), "R3 column direction", cmd_code, e.wr ? 3 : 2);
            chk(bopen[b] && brow[b] == e.row, "R9 column to wrong row", brow[b], e.row);
          end
          chk(cyc - last_act[b] >= T_RCD, "R5 activate-to-column gap", cyc - last_act[b], T_RCD);
          chk(cyc - last_col_any >= bl, "R8 column gap", cyc - last_col_any, bl);
          chk(resp_valid == 1, "R3 resp_valid", resp_valid, 1);
          chk(resp_write == (cmd_code == 3'd3), "R3 resp_write", resp_write, cmd_code == 3'd3);
          last_col[b] = cyc; last_col_any = cyc; col_times.push_back(cyc);
        end
        3'd4: begin
          chk(bopen[b], "R2 precharge of closed bank", bopen[b], 1);
          chk(cyc - last_col[b] >= bl, "R8 column-to-precharge gap", cyc - last_col[b], bl);
          if (!page_closed) begin
            if (exp_q.size() == 0) chk(0, "R9 precharge with no request", b, -1);
            else begin
              chk(exp_q[0].bank == b, "R11 precharge bank", b, exp_q[0].bank);
              chk(brow[b] != exp_q[0].row, "R9 precharge on row hit", brow[b], -1);
            end
          end
          bopen[b] = 0; last_pre[b] = cyc; pre_cnt++;
        end
        default: chk(0, "R2 illegal command code", cmd_code, 0);
      endcase
    end
  end

  // Driver: call at a negedge; returns at the negedge after acceptance
  task automatic send(input bit wr, input int bank, input int row, input int col);
    req_t e;
    req_valid = 1; req_write = wr;
    req_bank = BW'(bank); req_row = RW'(row); req_col = CW'(col);
    while (!req_ready) @(negedge clk);
    e.wr = wr; e.bank = bank; e.row = row; e.col = col;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle_drain();
    req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (T_RC + 20) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(cmd_code == 0, "R1 cmd after reset", cmd_code, 0);
    chk(resp_valid == 0, "R1 resp after reset", resp_valid, 0);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);

    // Open page, 4-beat bursts
    page_closed = 0; bl8_sel = 0;
    act_cnt = 0; pre_cnt = 0; act_times.delete(); col_times.delete();
    send(0, 0, 5, 1);
    send(1, 0, 5, 2);
    send(0, 0, 9, 3);
    send(0, 1, 3, 4);
    send(1, 2, 3, 5);
    send(0, 3, 1, 6);
    idle_drain();
    chk(act_cnt == 5, "R1 R9 activate count open policy", act_cnt, 5);
    chk(pre_cnt == 1, "R9 precharge count open policy", pre_cnt, 1);
    chk(col_times.size() == 6, "R3 column count", col_times.size(), 6);
    if (col_times.size() >= 2 && act_times.size() >= 1) begin
      chk(col_times[0] - act_times[0] == T_RCD, "R5 idle bank exact gap", col_times[0] - act_times[0], T_RCD);
      chk(col_times[1] - col_times[0] == 4, "R8 R4 back-to-back hit gap 4", col_times[1] - col_times[0], 4);
    end
    chk(bopen[0] && brow[0] == 9, "R9 row kept open", brow[0], 9);

    // Closed page, 8-beat bursts, back-to-back hit kept open by lookahead
    page_closed = 1; bl8_sel = 1;
    act_cnt = 0; pre_cnt = 0; act_times.delete(); col_times.delete();
    send(0, 4, 7, 0);
    send(1, 4, 7, 8);
    idle_drain();
    chk(act_cnt == 1, "R10 single activate for hit", act_cnt, 1);
    chk(pre_cnt == 1, "R10 one close", pre_cnt, 1);
    if (col_times.size() == 2)
      chk(col_times[1] - col_times[0] == 8, "R8 back-to-back hit gap 8", col_times[1] - col_times[0], 8);
    else chk(0, "R10 column count", col_times.size(), 2);
    chk(!bopen[4], "R10 bank closed after burst", bopen[4], 0);

    // Random traffic, closed then open policy
    for (int ph = 0; ph < 2; ph++) begin
      page_closed = (ph == 0); bl8_sel = (ph == 0);
      for (int n = 0; n < 120; n++) begin
        send($urandom_range(0, 1), $urandom_range(0, NB - 1), $urandom_range(0, 3), $urandom_range(0, 1023));
        if ($urandom_range(0, 3) == 0) begin
          req_valid = 0;
          repeat ($urandom_range(1, 12)) @(negedge clk);
        end
      end
      idle_drain();
      chk(exp_q.size() == 0, "R3 all requests served", exp_q.size(), 0);
      if (ph == 0) for (int i = 0; i < NB; i++)
        if (i != 0 && i != 1 && i != 2 && i != 3)
          chk(!bopen[i], "R10 bank closed after drain", bopen[i], 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule